// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block sits beside the page-load controller of an electrically erasable memory. It sees every write load the host makes: a 15-bit address within the page-command space and one data byte. It looks for two command sequences in that stream. The short one is a three-load unlock prefix. It arms protection for the end of the current write period and also lets the data loads that follow it in the same period be stored. The long one is a six-load sequence. It arms protection to switch off at the end of the period, and the data loads that follow it are stored as well.

For each load the block makes exactly one decision. The load is a command byte and is dropped, or it is data to commit, or it is a protected write. A protected write starts the programming timer but stores nothing. The controller raises a one-cycle period-end pulse when its programming period finishes. Only at that pulse does the protection state change. The nonvolatile protection bit is modelled as a register that reset clears to the unprotected state.

Top module: `wprot_sequencer`

## Requirements
- R1: After reset `prot_on` is 0, and every load that is not a command step is reported with `commit_ok`.
- R2: A load is a command step only if all 15 address bits and all 8 data bits equal the expected step exactly. The expected steps are: (0xAA @ 0x5555), then (0x55 @ 0x2AAA), then either (0xA0 @ 0x5555) to unlock, or (0x80 @ 0x5555), (0xAA @ 0x5555), (0x55 @ 0x2AAA), (0x20 @ 0x5555) to disable. A load that differs in any single bit is a data load.
- R3: Each load that matches its step is reported with `cmd_load` only. It is never committed and never starts a protected write.
- R4: A completed unlock prefix leaves `prot_on` unchanged until the cycle after the next `period_end`, when `prot_on` becomes 1. This holds even if no data follows.
- R5: A completed six-load disable sequence clears `prot_on` in the cycle after the next `period_end`, whether or not data follows. Data loads after it in the same period are committed.
- R6: While `prot_on` is 1 and no prefix has completed in the current period, a data load raises `prot_write` and not `commit_ok`.
- R7: While `prot_on` is 1, data loads that follow a completed unlock prefix in the same period raise `commit_ok`, and `prot_on` stays 1 after the period ends.
- R8: A load that does not match the expected next step, with one or more steps already matched, clears the progress. That load is itself handled as a data load; it does not start a new sequence.
- R9: After a sequence completes, all remaining loads of that period are data loads, including loads that equal command steps.
- R10: `period_end` discards any partly matched sequence. In a cycle with `period_end`, the current load is decided on the pre-pulse state, and the pulse then takes over the update.
- R11: With `ld_valid` high, exactly one of `commit_ok`, `cmd_load` and `prot_write` is 1. With `ld_valid` low, none is.
- R12: `prot_on` changes only in the cycle after a `period_end` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A write load is presented this cycle |
| ld_addr | input | 15 | Low address bits of the load |
| ld_data | input | 8 | Data byte of the load |
| period_end | input | 1 | One-cycle pulse at the end of the programming period |
| prot_on | output | 1 | Protection state now in force |
| commit_ok | output | 1 | Current load is data and may be stored |
| cmd_load | output | 1 | Current load is a command step and is dropped |
| prot_write | output | 1 | Current load starts the timer without storing |

## Verification
The hardest case to reach is a six-load disable sequence that breaks down late, at the fourth or fifth step, while protection is on. The shared two-load head of both sequences has to be matched first. Directed stimulus builds each partial path step by step and then breaks it with a single flipped bit, or with a `period_end` in the middle. A long pseudo-random run then draws loads mostly from the command token set, so that partial and overlapping sequences occur often. A queue-based reference model checks all four outputs on every clock.

// File: rtl/wprot_sequencer.sv
module wprot_sequencer #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          period_end,
  output logic          prot_on,
  output logic          commit_ok,
  output logic          cmd_load,
  output logic          prot_write
);
  localparam logic [AW-1:0] ADR_P = AW'(15'h5555);
  localparam logic [AW-1:0] ADR_Q = AW'(15'h2AAA);

  typedef enum logic [2:0] {ST_IDLE, ST_K1, ST_K2, ST_D3, ST_D4, ST_D5} step_t;

  step_t step, step_nx;
  logic  armed_on, armed_off, opened;
  logic  hit, fin_on, fin_off;

  wire at_p = ld_addr == ADR_P;
  wire at_q = ld_addr == ADR_Q;

  always_comb begin
    hit     = 1'b0;
    fin_on  = 1'b0;
    fin_off = 1'b0;
    step_nx = ST_IDLE;
    case (step)
      ST_IDLE: if (at_p && ld_data == 8'hAA) begin hit = 1'b1; step_nx = ST_K1; end
      ST_K1:   if (at_q && ld_data == 8'h55) begin hit = 1'b1; step_nx = ST_K2; end
      ST_K2:   if (at_p && ld_data == 8'hA0) begin hit = 1'b1; fin_on = 1'b1; end
               else if (at_p && ld_data == 8'h80) begin hit = 1'b1; step_nx = ST_D3; end
      ST_D3:   if (at_p && ld_data == 8'hAA) begin hit = 1'b1; step_nx = ST_D4; end
      ST_D4:   if (at_q && ld_data == 8'h55) begin hit = 1'b1; step_nx = ST_D5; end
      ST_D5:   if (at_p && ld_data == 8'h20) begin hit = 1'b1; fin_off = 1'b1; end
      default: ;
    endcase
  end

  assign cmd_load   = ld_valid && !opened && hit;
  assign commit_ok  = ld_valid && !cmd_load && (!prot_on || opened);
  assign prot_write = ld_valid && !cmd_load && prot_on && !opened;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_on   <= 1'b0;
      step      <= ST_IDLE;
      armed_on  <= 1'b0;
      armed_off <= 1'b0;
      opened    <= 1'b0;
    end else if (period_end) begin
      if (armed_on)       prot_on <= 1'b1;
      else if (armed_off) prot_on <= 1'b0;
      step      <= ST_IDLE;
      armed_on  <= 1'b0;
      armed_off <= 1'b0;
      opened    <= 1'b0;
    end else if (ld_valid && !opened) begin
      step <= step_nx;
      if (fin_on)  begin armed_on  <= 1'b1; opened <= 1'b1; end
      if (fin_off) begin armed_off <= 1'b1; opened <= 1'b1; end
    end
  end
endmodule

module wprot_sequencer_chk #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic [AW-1:0] ld_addr,
  input logic [DW-1:0] ld_data,
  input logic          period_end,
  input logic          prot_on,
  input logic          commit_ok,
  input logic          cmd_load,
  input logic          prot_write
);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $countones({commit_ok, cmd_load, prot_write}) == 1);

  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !(commit_ok || cmd_load || prot_write));

  a_r12_moves_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_on) |-> $past(period_end));

  a_r1_open_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !prot_on && !cmd_load) |-> commit_ok);

  a_r2_cmd_values: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |-> ((ld_addr == AW'(15'h5555) &&
                   (ld_data == 8'hAA || ld_data == 8'hA0 || ld_data == 8'h80 || ld_data == 8'h20)) ||
                  (ld_addr == AW'(15'h2AAA) && ld_data == 8'h55)));

  a_r6_locked_no_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && $past(period_end) && ld_valid) |-> !commit_ok);
endmodule

bind wprot_sequencer wprot_sequencer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
  .period_end(period_end), .prot_on(prot_on), .commit_ok(commit_ok),
  .cmd_load(cmd_load), .prot_write(prot_write)
);

// File: tb/tb_wprot_sequencer.sv
module tb_wprot_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [14:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        period_end = 1'b0;
  logic        prot_on, commit_ok, cmd_load, prot_write;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wprot_sequencer dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .period_end(period_end), .prot_on(prot_on), .commit_ok(commit_ok),
    .cmd_load(cmd_load), .prot_write(prot_write)
  );

  int en_pat[3]  = '{'h5555AA, 'h2AAA55, 'h5555A0};
  int dis_pat[6] = '{'h5555AA, 'h2AAA55, 'h555580, 'h5555AA, 'h2AAA55, 'h555520};
  int held[$];
  bit m_prot = 0, m_done = 0;
  int m_pend = 0;

  function automatic bit follows(input int pat[], input int n, input int key);
    if (held.size() >= n) return 0;
    foreach (held[i]) if (held[i] != pat[i]) return 0;
    return pat[held.size()] == key;
  endfunction

  task automatic vec(input bit v, input int a, input int d, input bit pe, input string tag);
    int key;
    bit m_cmd, e_commit, e_pw;
    @(negedge clk);
    ld_valid = v; ld_addr = a[14:0]; ld_data = d[7:0]; period_end = pe;
    key = ((a & 'h7fff) << 8) | (d & 'hff);
    m_cmd = 0;
    if (v && !m_done)
      m_cmd = follows(en_pat, 3, key) || follows(dis_pat, 6, key);
    e_commit = v && !m_cmd && (!m_prot || m_done);
    e_pw = v && !m_cmd && m_prot && !m_done;
    #1;
    n_vec++;
    if ({prot_on, commit_ok, cmd_load, prot_write} !== {m_prot, e_commit, m_cmd, e_pw}) begin
      n_bad++;
      $display("FAIL %s: a=%h d=%h got prot/commit/cmd/pw=%b expected %b", tag, a, d,
               {prot_on, commit_ok, cmd_load, prot_write}, {m_prot, e_commit, m_cmd, e_pw});
    end
    if (pe) begin
      if (m_pend == 1) m_prot = 1;
      else if (m_pend == 2) m_prot = 0;
      m_pend = 0; m_done = 0; held.delete();
    end else if (v && !m_done) begin
      if (m_cmd) begin
        held.push_back(key);
        if (held.size() == 3 && held[2] == 'h5555A0) begin m_pend = 1; m_done = 1; held.delete(); end
        else if (held.size() == 6) begin m_pend = 2; m_done = 1; held.delete(); end
      end else held.delete();
    end
  endtask

  task automatic ld(input int a, input int d, input string tag); vec(1, a, d, 0, tag); endtask
  task automatic idle(input string tag); vec(0, 0, 0, 0, tag); endtask
  task automatic pend(input string tag); vec(0, 0, 0, 1, tag); endtask
  task automatic unlock(input string tag);
    ld('h5555, 'hAA, tag); ld('h2AAA, 'h55, tag); ld('h5555, 'hA0, tag);
  endtask
  task automatic disable_seq(input string tag);
    ld('h5555, 'hAA, tag); ld('h2AAA, 'h55, tag); ld('h5555, 'h80, tag);
    ld('h5555, 'hAA, tag); ld('h2AAA, 'h55, tag); ld('h5555, 'h20, tag);
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lf = 32'h1ACE5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1"); ld('h0100, 'h12, "R1"); ld('h5555, 'h00, "R1");
    // R3 R4 R9: unlock while open, then look-alike loads are data
    unlock("R3"); ld('h5555, 'hAA, "R9"); ld('h2AAA, 'h55, "R9");
    idle("R4"); idle("R4"); pend("R4"); idle("R4"); idle("R12");
    // R6: protected, no prefix
    ld('h0040, 'h77, "R6"); ld('h1234, 'hFF, "R6"); pend("R6"); idle("R6");
    // R7: prefix then data, state stays set
    unlock("R7"); ld('h0080, 'h01, "R7"); ld('h0081, 'h02, "R7"); pend("R7"); idle("R7");
    // R2: single-bit differences are data
    ld('h5554, 'hAA, "R2"); ld('h5555, 'hAB, "R2"); ld('h5555, 'hAA, "R2");
    ld('h2AAB, 'h55, "R2"); pend("R2");
    // R8: break after two steps; breaking load is data, no restart
    ld('h5555, 'hAA, "R8"); ld('h2AAA, 'h55, "R8"); ld('h5555, 'h33, "R8");
    ld('h2AAA, 'h55, "R8"); ld('h5555, 'hA0, "R8"); pend("R8");
    // R8: late break inside the disable path
    ld('h5555, 'hAA, "R8"); ld('h2AAA, 'h55, "R8"); ld('h5555, 'h80, "R8");
    ld('h5555, 'hAA, "R8"); ld('h2AAA, 'h54, "R8"); pend("R8"); idle("R8");
    // R10: pulse mid-sequence drops progress
    ld('h5555, 'hAA, "R10"); pend("R10"); ld('h2AAA, 'h55, "R10"); ld('h5555, 'hA0, "R10");
    vec(1, 'h5555, 'hAA, 1, "R10"); ld('h2AAA, 'h55, "R10"); pend("R10");
    // R5: disable with data
    disable_seq("R5"); ld('h0200, 'h5A, "R5"); idle("R5"); pend("R5"); idle("R5");
    // R4 R5: enable and disable with no data
    unlock("R4"); pend("R4"); idle("R4");
    disable_seq("R5"); pend("R5"); idle("R5");
    // R1: open device after a mismatch
    ld('h5555, 'hAA, "R8"); ld('h0100, 'h12, "R8"); pend("R8");
    // R11 R12: pseudo-random sweep biased to command tokens
    for (int i = 0; i < 4000; i++) begin
      int r, a, d;
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB4BCD35C : 0);
      r = lf & 'hff;
      case (r % 8)
        0, 1: begin a = 'h5555; d = 'hAA; end
        2:    begin a = 'h2AAA; d = 'h55; end
        3:    begin a = 'h5555; d = ((r >> 3) & 1) ? 'hA0 : 'h80; end
        4:    begin a = 'h5555; d = 'h20; end
        default: begin a = (lf >> 8) & 'h7fff; d = (lf >> 4) & 'hff; end
      endcase
      vec(((r >> 4) % 5) != 0, a, d, ((lf >> 20) % 11) == 0, "R11");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule